// File: doc/BRIEF.md
# Program Memory Table Reader

This block moves single bytes between a 16-bit-word program memory and an 8-bit data latch under control of a 21-bit byte pointer. Software sees the pointer as three byte-wide registers (low, high, upper) and the latch as a fourth, and may write any of them at any time. A table operation is issued with a read/write flag and one of four pointer-update modes.

A read operation drives a word request to program memory, selects the low or high byte of the returned word from pointer bit 0, and loads it into the latch. A write operation copies the latch into one slot of an eight-byte holding buffer, chosen by the low three bits of the addressed pointer value. The holding buffer is where a later programming sequence would take its data from. That sequence, and the memory array, lie outside this block.

Top module: `prog_table_reader`

## Requirements
- R1: After reset the pointer, the latch and all eight holding bytes are zero, and `busy` and `pm_req` are low.
- R2: `sw_sel` picks a software register: 0 is pointer bits 7:0, 1 is pointer bits 15:8, 2 is pointer bits 20:16 (bits 7:5 read as zero, and writes to them are dropped), and 3 is the latch. `sw_rdata` shows the selected register combinationally. `sw_wr_en` writes `sw_wdata` into it at the clock edge.
- R3: An operation is accepted on an edge where `op_valid` is high and `busy` is low. An accepted read raises `pm_req` for exactly the following cycle, with `pm_word_addr` equal to bits 20:1 of the addressed pointer value. `busy` is high for that cycle and the next one, and the latch takes the fetched byte at the edge that ends the second busy cycle. The memory returns `pm_rdata` one cycle after it sees `pm_req`.
- R4: Bit 0 of the addressed pointer value selects the byte: 0 takes `pm_rdata[7:0]`, 1 takes `pm_rdata[15:8]`.
- R5: `op_mode` selects the addressed value and the new pointer, both applied at the accept edge. 0 keeps the pointer and addresses it. 1 addresses the pointer and then adds 1. 2 addresses the pointer and then subtracts 1. 3 adds 1 and addresses the incremented value.
- R6: Pointer arithmetic wraps modulo 2^21. 0x1FFFFF + 1 gives 0, and 0 − 1 gives 0x1FFFFF.
- R7: An accepted write (`op_write`=1) stores the latch value in holding byte N, where N is bits 2:0 of the addressed value. The pointer is updated as in R5. The write completes at the accept edge and raises neither `busy` nor `pm_req`. Holding byte N appears on `hold_bytes[8N+7:8N]`.
- R8: `op_valid` is ignored while `busy` is high. It changes neither the pointer, the latch nor the holding buffer, and it issues no further `pm_req`.
- R9: If a software pointer write and an operation accept fall on the same edge, the operation addresses the old pointer. The written byte then takes `sw_wdata`, and the other pointer bytes take the operation's update.
- R10: If a software latch write lands on the edge where a read captures, the captured byte wins. If it lands on the edge where a write is accepted, the holding byte receives the latch value from before that edge, and the latch then takes `sw_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_en | input | 1 | Software register write strobe |
| sw_sel | input | 2 | Software register select (R2) |
| sw_wdata | input | 8 | Software write data |
| sw_rdata | output | 8 | Selected register value |
| op_valid | input | 1 | Table operation request |
| op_write | input | 1 | 1 = write to holding buffer, 0 = read from memory |
| op_mode | input | 2 | Pointer-update mode (R5) |
| busy | output | 1 | Read in progress |
| pm_req | output | 1 | Program memory read request |
| pm_word_addr | output | 20 | Program memory word address |
| pm_rdata | input | 16 | Program memory word returned |
| hold_bytes | output | 64 | Holding buffer contents, byte N at bits 8N+7:8N |

## Verification
The collisions that matter are software register writes landing on the same edge as the block's own updates. The bench writes the pointer low byte on the edge that accepts a post-increment read, and expects the fetched byte to come from the old address while the pointer holds the merged value. It also writes the latch on the capture edge of a read, and on the accept edge of a write, and expects the fetched byte and the pre-edge latch value respectively. A second operation issued during a read must leave the pointer, the latch and the holding buffer untouched.

// File: rtl/tpr_pkg.sv
package tpr_pkg;

    typedef enum logic [1:0] {
        MODE_KEEP     = 2'd0,
        MODE_POST_INC = 2'd1,
        MODE_POST_DEC = 2'd2,
        MODE_PRE_INC  = 2'd3
    } tp_mode_e;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_RET  = 2'd2
    } fetch_state_e;

    localparam logic [1:0] SEL_PTR_LO = 2'd0;
    localparam logic [1:0] SEL_PTR_HI = 2'd1;
    localparam logic [1:0] SEL_PTR_UP = 2'd2;
    localparam logic [1:0] SEL_LATCH  = 2'd3;

endpackage

// File: rtl/tpr_ptr_math.sv
module tpr_ptr_math
    import tpr_pkg::*;
#(
    parameter int PTR_W = 21
) (
    input  logic [PTR_W-1:0] ptr,
    input  tp_mode_e         mode,
    output logic [PTR_W-1:0] eff_addr,
    output logic [PTR_W-1:0] ptr_next
);

    logic [PTR_W-1:0] ptr_inc;
    logic [PTR_W-1:0] ptr_dec;

    assign ptr_inc = ptr + PTR_W'(1);
    assign ptr_dec = ptr - PTR_W'(1);

    always_comb begin
        eff_addr = ptr;
        ptr_next = ptr;
        unique case (mode)
            MODE_KEEP:     ptr_next = ptr;
            MODE_POST_INC: ptr_next = ptr_inc;
            MODE_POST_DEC: ptr_next = ptr_dec;
            MODE_PRE_INC: begin
                ptr_next = ptr_inc;
                eff_addr = ptr_inc;
            end
            default:       ptr_next = ptr;
        endcase
    end

endmodule

// File: rtl/tpr_fetch_ctrl.sv
module tpr_fetch_ctrl
    import tpr_pkg::*;
#(
    parameter int PTR_W  = 21,
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [PTR_W-1:0]    start_addr,
    input  logic [2*DATA_W-1:0] pm_rdata,
    output logic                busy,
    output logic                pm_req,
    output logic [PTR_W-2:0]    pm_word_addr,
    output logic                cap_valid,
    output logic [DATA_W-1:0]   cap_data
);

    typedef struct packed {
        fetch_state_e     state;
        logic [PTR_W-1:0] addr;
    } fetch_regs_t;

    fetch_regs_t fr_d, fr_q;

    always_comb begin
        fr_d = fr_q;
        unique case (fr_q.state)
            FS_IDLE: begin
                if (start) begin
                    fr_d.state = FS_REQ;
                    fr_d.addr  = start_addr;
                end
            end
            FS_REQ:  fr_d.state = FS_RET;
            FS_RET:  fr_d.state = FS_IDLE;
            default: fr_d.state = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fr_q <= '{state: FS_IDLE, addr: '0};
        end else begin
            fr_q <= fr_d;
        end
    end

    assign busy         = (fr_q.state != FS_IDLE);
    assign pm_req       = (fr_q.state == FS_REQ);
    assign pm_word_addr = fr_q.addr[PTR_W-1:1];
    assign cap_valid    = (fr_q.state == FS_RET);
    assign cap_data     = fr_q.addr[0] ? pm_rdata[2*DATA_W-1:DATA_W]
                                       : pm_rdata[DATA_W-1:0];

    // R3: request lasts one cycle and is followed by the return cycle
    p_req_single_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pm_req |=> (!pm_req && cap_valid && busy));

    // R3: a started fetch requests memory in the next cycle
    p_start_to_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> pm_req);

    // R8: a new fetch never starts while one is running
    p_no_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R3: word address held steady from request to capture
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pm_req |=> $stable(pm_word_addr));

endmodule

// File: rtl/tpr_hold_buf.sv
module tpr_hold_buf #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [DEPTH*DATA_W-1:0] bytes_flat
);

    logic [DATA_W-1:0] slot_d [DEPTH];
    logic [DATA_W-1:0] slot_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            slot_d[i] = slot_q[i];
        end
        if (wr_en) begin
            slot_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= slot_d[i];
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign bytes_flat[g*DATA_W +: DATA_W] = slot_q[g];

        // R7: the addressed slot takes the data, others keep theirs
        p_slot_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_idx == IDX_W'(g))) |=> (slot_q[g] == $past(wr_data)));

        p_slot_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_idx == IDX_W'(g))) |=> $stable(slot_q[g]));
    end

endmodule

// File: rtl/prog_table_reader.sv
module prog_table_reader
    import tpr_pkg::*;
#(
    parameter int PTR_W      = 21,
    parameter int DATA_W     = 8,
    parameter int HOLD_DEPTH = 8,
    localparam int WORD_W     = PTR_W - 1,
    localparam int HOLD_IDX_W = $clog2(HOLD_DEPTH),
    localparam int UP_W       = PTR_W - 2 * DATA_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sw_wr_en,
    input  logic [1:0]                   sw_sel,
    input  logic [DATA_W-1:0]            sw_wdata,
    output logic [DATA_W-1:0]            sw_rdata,
    input  logic                         op_valid,
    input  logic                         op_write,
    input  logic [1:0]                   op_mode,
    output logic                         busy,
    output logic                         pm_req,
    output logic [WORD_W-1:0]            pm_word_addr,
    input  logic [2*DATA_W-1:0]          pm_rdata,
    output logic [HOLD_DEPTH*DATA_W-1:0] hold_bytes
);

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic [DATA_W-1:0] latch;
    } top_regs_t;

    top_regs_t rg_d, rg_q;

    logic              accept;
    logic              rd_start;
    logic              wr_go;
    logic [PTR_W-1:0]  eff_addr;
    logic [PTR_W-1:0]  ptr_next;
    logic              cap_valid;
    logic [DATA_W-1:0] cap_data;

    assign accept   = op_valid && !busy;
    assign rd_start = accept && !op_write;
    assign wr_go    = accept && op_write;

    tpr_ptr_math #(
        .PTR_W (PTR_W)
    ) u_ptr_math (
        .ptr      (rg_q.ptr),
        .mode     (tp_mode_e'(op_mode)),
        .eff_addr (eff_addr),
        .ptr_next (ptr_next)
    );

    tpr_fetch_ctrl #(
        .PTR_W  (PTR_W),
        .DATA_W (DATA_W)
    ) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (rd_start),
        .start_addr   (eff_addr),
        .pm_rdata     (pm_rdata),
        .busy         (busy),
        .pm_req       (pm_req),
        .pm_word_addr (pm_word_addr),
        .cap_valid    (cap_valid),
        .cap_data     (cap_data)
    );

    tpr_hold_buf #(
        .DEPTH  (HOLD_DEPTH),
        .DATA_W (DATA_W)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_go),
        .wr_idx     (eff_addr[HOLD_IDX_W-1:0]),
        .wr_data    (rg_q.latch),
        .bytes_flat (hold_bytes)
    );

    always_comb begin
        rg_d = rg_q;
        if (accept) begin
            rg_d.ptr = ptr_next;
        end
        if (sw_wr_en) begin
            unique case (sw_sel)
                SEL_PTR_LO: rg_d.ptr[DATA_W-1:0]          = sw_wdata;
                SEL_PTR_HI: rg_d.ptr[2*DATA_W-1:DATA_W]   = sw_wdata;
                SEL_PTR_UP: rg_d.ptr[PTR_W-1:2*DATA_W]    = sw_wdata[UP_W-1:0];
                default:    rg_d.latch                    = sw_wdata;
            endcase
        end
        if (cap_valid) begin
            rg_d.latch = cap_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rg_q <= '{ptr: '0, latch: '0};
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        unique case (sw_sel)
            SEL_PTR_LO: sw_rdata = rg_q.ptr[DATA_W-1:0];
            SEL_PTR_HI: sw_rdata = rg_q.ptr[2*DATA_W-1:DATA_W];
            SEL_PTR_UP: sw_rdata = DATA_W'(rg_q.ptr[PTR_W-1:2*DATA_W]);
            default:    sw_rdata = rg_q.latch;
        endcase
    end

    // R8: operations offered during a fetch leave the pointer alone
    p_busy_ignores_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_valid && !sw_wr_en) |=> (rg_q.ptr == $past(rg_q.ptr)));

    // R5: keep mode leaves the pointer unchanged
    p_keep_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (op_mode == 2'd0) && !sw_wr_en) |=> (rg_q.ptr == $past(rg_q.ptr)));

    // R5, R6: post-increment advances by one modulo the pointer range
    p_post_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (op_mode == 2'd1) && !sw_wr_en)
            |=> (rg_q.ptr == PTR_W'($past(rg_q.ptr) + PTR_W'(1))));

    // R7: a table write never occupies the memory port
    p_write_no_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> (!pm_req && !busy));

    // R10: the capture edge overrides a software latch write
    p_capture_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> (rg_q.latch == $past(cap_data)));

endmodule

// File: tb/prog_table_reader_tb_top.sv
module prog_table_reader_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sw_wr_en;
    logic [1:0]  sw_sel;
    logic [7:0]  sw_wdata;
    logic [7:0]  sw_rdata;
    logic        op_valid;
    logic        op_write;
    logic [1:0]  op_mode;
    logic        busy;
    logic        pm_req;
    logic [19:0] pm_word_addr;
    logic [15:0] pm_rdata;
    logic [63:0] hold_bytes;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    prog_table_reader dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_wr_en     (sw_wr_en),
        .sw_sel       (sw_sel),
        .sw_wdata     (sw_wdata),
        .sw_rdata     (sw_rdata),
        .op_valid     (op_valid),
        .op_write     (op_write),
        .op_mode      (op_mode),
        .busy         (busy),
        .pm_req       (pm_req),
        .pm_word_addr (pm_word_addr),
        .pm_rdata     (pm_rdata),
        .hold_bytes   (hold_bytes)
    );

    function automatic logic [15:0] mem_word(input logic [19:0] wa);
        return {wa[7:0] + wa[19:12] + 8'h33, wa[7:0] ^ wa[15:8] ^ 8'h5A};
    endfunction

    function automatic logic [7:0] mem_byte(input logic [20:0] a);
        logic [15:0] w;
        w = mem_word(a[20:1]);
        return a[0] ? w[15:8] : w[7:0];
    endfunction

    function automatic logic [20:0] model_eff(input logic [20:0] p, input logic [1:0] m);
        return (m == 2'd3) ? p + 21'd1 : p;
    endfunction

    function automatic logic [20:0] model_next(input logic [20:0] p, input logic [1:0] m);
        case (m)
            2'd1:    return p + 21'd1;
            2'd2:    return p - 21'd1;
            2'd3:    return p + 21'd1;
            default: return p;
        endcase
    endfunction

    // program memory model: returns the word one cycle after the request
    always @(posedge clk) begin
        if (pm_req) pm_rdata <= mem_word(pm_word_addr);
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sw_write(input logic [1:0] sel, input logic [7:0] d);
        sw_wr_en = 1'b1; sw_sel = sel; sw_wdata = d;
        @(negedge clk);
        sw_wr_en = 1'b0;
    endtask

    task automatic set_ptr(input logic [20:0] p);
        sw_write(2'd0, p[7:0]);
        sw_write(2'd1, p[15:8]);
        sw_write(2'd2, {3'b000, p[20:16]});
    endtask

    task automatic get_reg(input logic [1:0] sel, output logic [7:0] v);
        sw_sel = sel;
        #1;
        v = sw_rdata;
    endtask

    task automatic get_ptr(output logic [20:0] p);
        logic [7:0] b0, b1, b2;
        get_reg(2'd0, b0);
        get_reg(2'd1, b1);
        get_reg(2'd2, b2);
        p = {b2[4:0], b1, b0};
    endtask

    // read with full timing checks; entered and left at a negative edge
    task automatic do_read(input logic [1:0] m, input logic [20:0] start_p, input string tag);
        logic [20:0] e, p;
        logic [7:0]  l;
        e = model_eff(start_p, m);
        op_valid = 1'b1; op_write = 1'b0; op_mode = m;
        @(negedge clk);
        op_valid = 1'b0;
        chk({tag, " R3 pm_req in request cycle"}, 64'(pm_req), 64'd1);
        chk({tag, " R3 busy in request cycle"}, 64'(busy), 64'd1);
        chk({tag, " R3 word address"}, 64'(pm_word_addr), 64'(e[20:1]));
        @(negedge clk);
        chk({tag, " R3 busy in return cycle, no request"}, 64'({busy, pm_req}), 64'b10);
        @(negedge clk);
        chk({tag, " R3 busy cleared"}, 64'(busy), 64'd0);
        get_reg(2'd3, l);
        chk({tag, " R4 latched byte"}, 64'(l), 64'(mem_byte(e)));
        get_ptr(p);
        chk({tag, " R5 pointer after read"}, 64'(p), 64'(model_next(start_p, m)));
    endtask

    task automatic do_write(input logic [1:0] m);
        op_valid = 1'b1; op_write = 1'b1; op_mode = m;
        @(negedge clk);
        op_valid = 1'b0; op_write = 1'b0;
    endtask

    task automatic t_reset;
        logic [20:0] p;
        logic [7:0]  l;
        get_ptr(p);
        get_reg(2'd3, l);
        chk("R1 pointer reset", 64'(p), 64'd0);
        chk("R1 latch reset", 64'(l), 64'd0);
        chk("R1 busy/pm_req reset", 64'({busy, pm_req}), 64'd0);
        chk("R1 holding buffer reset", hold_bytes, 64'd0);
    endtask

    task automatic t_sw_regs;
        logic [7:0] v;
        sw_write(2'd2, 8'hFF);
        get_reg(2'd2, v);
        chk("R2 upper byte bits 7:5 read zero", 64'(v), 64'h1F);
        sw_write(2'd0, 8'hA7);
        sw_write(2'd1, 8'h3C);
        get_reg(2'd0, v);
        chk("R2 low byte readback", 64'(v), 64'hA7);
        get_reg(2'd1, v);
        chk("R2 high byte readback", 64'(v), 64'h3C);
        sw_write(2'd3, 8'h96);
        get_reg(2'd3, v);
        chk("R2 latch readback", 64'(v), 64'h96);
    endtask

    task automatic t_modes;
        set_ptr(21'h012344);
        do_read(2'd0, 21'h012344, "keep even");
        set_ptr(21'h0ABC01);
        do_read(2'd1, 21'h0ABC01, "post-inc odd");
        set_ptr(21'h155556);
        do_read(2'd2, 21'h155556, "post-dec even");
        set_ptr(21'h07F0FE);
        do_read(2'd3, 21'h07F0FE, "pre-inc to odd");
    endtask

    task automatic t_wrap;
        set_ptr(21'h1FFFFF);
        do_read(2'd1, 21'h1FFFFF, "R6 post-inc wrap");
        set_ptr(21'h000000);
        do_read(2'd2, 21'h000000, "R6 post-dec wrap");
        set_ptr(21'h1FFFFF);
        do_read(2'd3, 21'h1FFFFF, "R6 pre-inc wrap");
    endtask

    task automatic t_write;
        logic [20:0] p;
        set_ptr(21'h000105);
        sw_write(2'd3, 8'hC1);
        do_write(2'd1);
        chk("R7 no busy/pm_req after write", 64'({busy, pm_req}), 64'd0);
        chk("R7 holding byte 5", 64'(hold_bytes[47:40]), 64'hC1);
        get_ptr(p);
        chk("R7 pointer post-inc after write", 64'(p), 64'h000106);
        sw_write(2'd3, 8'h2D);
        set_ptr(21'h000207);
        do_write(2'd3);
        chk("R7 pre-inc write lands in byte 0", 64'(hold_bytes[7:0]), 64'h2D);
        chk("R7 byte 5 untouched", 64'(hold_bytes[47:40]), 64'hC1);
        get_ptr(p);
        chk("R7 pointer after pre-inc write", 64'(p), 64'h000208);
    endtask

    task automatic t_busy_ignore;
        logic [20:0] p;
        logic [63:0] hb;
        logic [7:0]  l;
        int          reqs;
        hb = hold_bytes;
        set_ptr(21'h003012);
        op_valid = 1'b1; op_write = 1'b0; op_mode = 2'd0;
        @(negedge clk);
        op_write = 1'b1; op_mode = 2'd1;   // still valid while busy
        reqs = 0;
        for (int i = 0; i < 2; i++) begin
            if (pm_req) reqs++;
            @(negedge clk);
        end
        op_valid = 1'b0; op_write = 1'b0;
        if (pm_req) reqs++;
        chk("R8 only one memory request", 64'(reqs), 64'd1);
        get_ptr(p);
        chk("R8 pointer unchanged", 64'(p), 64'h003012);
        chk("R8 holding buffer unchanged", hold_bytes, hb);
        get_reg(2'd3, l);
        chk("R8 latch holds fetched byte", 64'(l), 64'(mem_byte(21'h003012)));
    endtask

    task automatic t_same_cycle;
        logic [20:0] p;
        logic [7:0]  l;
        // R9: pointer low byte written on the accept edge of a post-inc read
        set_ptr(21'h000120);
        op_valid = 1'b1; op_write = 1'b0; op_mode = 2'd1;
        sw_wr_en = 1'b1; sw_sel = 2'd0; sw_wdata = 8'h55;
        @(negedge clk);
        op_valid = 1'b0; sw_wr_en = 1'b0;
        chk("R9 read uses old pointer", 64'(pm_word_addr), 64'(21'h000120 >> 1));
        @(negedge clk);
        // R10: latch write on the capture edge
        sw_wr_en = 1'b1; sw_sel = 2'd3; sw_wdata = 8'hEE;
        @(negedge clk);
        sw_wr_en = 1'b0;
        get_reg(2'd3, l);
        chk("R10 captured byte beats software latch write", 64'(l), 64'(mem_byte(21'h000120)));
        get_ptr(p);
        chk("R9 merged pointer", 64'(p), 64'h000155);
        // R10: latch write on the accept edge of a table write
        sw_write(2'd3, 8'h11);
        set_ptr(21'h000003);
        op_valid = 1'b1; op_write = 1'b1; op_mode = 2'd0;
        sw_wr_en = 1'b1; sw_sel = 2'd3; sw_wdata = 8'h22;
        @(negedge clk);
        op_valid = 1'b0; op_write = 1'b0; sw_wr_en = 1'b0;
        chk("R10 holding byte 3 gets old latch", 64'(hold_bytes[31:24]), 64'h11);
        get_reg(2'd3, l);
        chk("R10 latch takes software value", 64'(l), 64'h22);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sw_wr_en = 1'b0; sw_sel = 2'd0; sw_wdata = 8'h00;
        op_valid = 1'b0; op_write = 1'b0; op_mode = 2'd0; pm_rdata = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sw_regs();
        t_modes();
        t_wrap();
        t_write();
        t_busy_ignore();
        t_same_cycle();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule